// File: doc/BRIEF.md
# Fixed-OR Programmable Sum-of-Products Array

This block models a small programmable logic array in which only the AND plane is configurable. Each of eight outputs owns a private group of seven product terms, which are wired permanently to that output's OR gate. An eighth term per output acts as the enable for the output's three-state driver. Every product term can select the true line, the complement line, both, or neither, of each of sixteen array signals. Ten of those signals come from dedicated input pins. The other six come back from output pins.

The configuration is a chain of 2048 fuse bits. It is shifted in one bit per clock while program mode is high, and it is held otherwise. Each output pin carries the complement of the OR of its seven terms. Six pins are bidirectional. Their drivers are modelled as separate value and enable ports, and the level actually present on each such pin returns to the block on a feedback input. A pin whose driver is disabled therefore behaves as one more input. A pin that is driven can pass a helper term into a second pass through the array.

Top module: `fixed_or_pal`

## Requirements
- R1: After a synchronous reset, every fuse is intact, every `pin_oe` bit is 0 and every `pin_out` bit is 1.
- R2: While `prog_mode` and `cfg_shift` are both high, each rising clock edge shifts `cfg_bit` into fuse index 0, and every other fuse moves up one index. After 2048 shifts, the first bit sent sits at index 2047.
- R2 (layout): Fuse index = ((o*8)+t)*32 + 2*s + c, where o is the output 0..7 and t is the term 0..7. Term 0 is the enable term and terms 1..7 are the OR terms. The signal s counts 0..9 for `ded_in[s]` and 10..15 for `fb_in[s-10]`. c is 0 for the true line and 1 for the complement line. A fuse value of 1 means the line is connected.
- R3: When `prog_mode` or `cfg_shift` is low, the fuse contents do not change, so the logic function stays the same.
- R4: While `prog_mode` is high, every `pin_oe` bit is 0.
- R5: A term with all 32 fuses intact always evaluates to 0. A term with all 32 fuses blown always evaluates to 1.
- R6: `pin_out[o]` is the complement of the OR of terms 1..7 of output o. Terms of one output have no effect on any other output.
- R7: Outside program mode, `pin_oe[o]` equals enable term 0 of output o.
- R8: `fb_in[k]` enters the array as signal 10+k whether or not output k is driven. A pin whose driver is disabled can therefore serve as an extra input. Outputs 6 and 7 have no feedback.
- R9: A helper function driven on a feedback output can be combined by another output in a second pass through the array.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the fuse chain |
| rst | input | 1 | Synchronous active-high reset; sets all fuses intact |
| prog_mode | input | 1 | Program mode; allows shifting and disables all drivers |
| cfg_shift | input | 1 | Shift enable for the fuse chain |
| cfg_bit | input | 1 | Serial fuse data, highest index first |
| ded_in | input | 10 | Dedicated input pins |
| fb_in | input | 6 | Level present on bidirectional pins 0..5 |
| pin_out | output | 8 | Value each output driver would place on its pin |
| pin_oe | output | 8 | Three-state enable of each output driver |

## Verification
The hardest situation to reach from the ports is a two-pass function. There, one output's driven value must settle, travel around through its feedback input, and then shape a second output. The bench enables the helper output and then iterates: it drives each feedback input from the block's own value when that pin is enabled, or from an external level when it is not, until the pins settle. It then compares the second output against a closed-form equation computed from the dedicated inputs alone. A separate sweep disables every feedback pin and drives the pins externally, to show that they act as inputs.

// File: rtl/pal_pkg.sv
package pal_pkg;
  localparam int DED_PINS   = 10;
  localparam int FB_PINS    = 6;
  localparam int OUT_PINS   = 8;
  localparam int OR_TERMS   = 7;

  // base index of the fuse slice of term t of output o
  function automatic int term_base(int o, int t, int terms_per_out, int term_bits);
    return (o * terms_per_out + t) * term_bits;
  endfunction
endpackage

// File: rtl/pal_fuse_chain.sv
module pal_fuse_chain #(
  parameter int N_FUSE = 2048
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              prog_mode,
  input  logic              cfg_shift,
  input  logic              cfg_bit,
  output logic [N_FUSE-1:0] fuses
);
  logic shift_now;
  assign shift_now = prog_mode && cfg_shift;

  always_ff @(posedge clk) begin
    if (rst)            fuses <= '1;
    else if (shift_now) fuses <= {fuses[N_FUSE-2:0], cfg_bit};
  end

  // serial bit lands at index 0 on each shift
  assert_shift_in_R2: assert property (@(posedge clk) disable iff (rst)
    shift_now |=> fuses[0] == $past(cfg_bit));

  // contents held when not shifting
  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !shift_now |=> $stable(fuses));
endmodule

// File: rtl/pal_product_term.sv
module pal_product_term #(
  parameter int N_SIG = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [2*N_SIG-1:0] fuse,
  input  logic [N_SIG-1:0]   sig,
  output logic               term
);
  localparam int LINES = 2 * N_SIG;
  logic [LINES-1:0] line;

  always_comb begin
    for (int s = 0; s < N_SIG; s++) begin
      line[2*s]   = sig[s];
      line[2*s+1] = ~sig[s];
    end
  end

  // a blown fuse lets its line float high into the AND
  assign term = &(line | ~fuse);

  assert_dead_term_R5: assert property (@(posedge clk) disable iff (rst)
    (&fuse) |-> !term);

  assert_open_term_R5: assert property (@(posedge clk) disable iff (rst)
    (fuse == '0) |-> term);
endmodule

// File: rtl/pal_output_cell.sv
module pal_output_cell #(
  parameter int N_TERMS = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               prog_mode,
  input  logic [N_TERMS-1:0] terms,
  output logic               pin_out,
  output logic               pin_oe
);
  logic or_hit;
  assign or_hit  = |terms[N_TERMS-1:1];
  assign pin_out = ~or_hit;
  assign pin_oe  = terms[0] & ~prog_mode;

  assert_low_on_term_R6: assert property (@(posedge clk) disable iff (rst)
    ($countones(terms[N_TERMS-1:1]) != 0) |-> !pin_out);

  assert_prog_hiz_R4: assert property (@(posedge clk) disable iff (rst)
    prog_mode |-> !pin_oe);
endmodule

// File: rtl/fixed_or_pal.sv
module fixed_or_pal
  import pal_pkg::*;
#(
  parameter int N_DED   = DED_PINS,
  parameter int N_FB    = FB_PINS,
  parameter int N_OUT   = OUT_PINS,
  parameter int N_OR    = OR_TERMS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             prog_mode,
  input  logic             cfg_shift,
  input  logic             cfg_bit,
  input  logic [N_DED-1:0] ded_in,
  input  logic [N_FB-1:0]  fb_in,
  output logic [N_OUT-1:0] pin_out,
  output logic [N_OUT-1:0] pin_oe
);
  localparam int N_SIG     = N_DED + N_FB;
  localparam int TERM_BITS = 2 * N_SIG;
  localparam int TPO       = N_OR + 1;
  localparam int N_FUSE    = N_OUT * TPO * TERM_BITS;

  logic [N_FUSE-1:0] fuses;
  logic [N_SIG-1:0]  sig_bus;

  assign sig_bus = {fb_in, ded_in};

  pal_fuse_chain #(.N_FUSE(N_FUSE)) u_chain (
    .clk       (clk),
    .rst       (rst),
    .prog_mode (prog_mode),
    .cfg_shift (cfg_shift),
    .cfg_bit   (cfg_bit),
    .fuses     (fuses)
  );

  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    logic [TPO-1:0] tv;
    for (genvar t = 0; t < TPO; t++) begin : g_term
      pal_product_term #(.N_SIG(N_SIG)) u_pt (
        .clk  (clk),
        .rst  (rst),
        .fuse (fuses[term_base(o, t, TPO, TERM_BITS) +: TERM_BITS]),
        .sig  (sig_bus),
        .term (tv[t])
      );
    end
    pal_output_cell #(.N_TERMS(TPO)) u_cell (
      .clk       (clk),
      .rst       (rst),
      .prog_mode (prog_mode),
      .terms     (tv),
      .pin_out   (pin_out[o]),
      .pin_oe    (pin_oe[o])
    );
  end

  // right after reset all drivers are off and all pins read high
  assert_reset_hiz_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pin_oe == '0 && pin_out == '1));
endmodule

// File: tb/test_fixed_or_pal.sv
module test_fixed_or_pal;
  localparam int CLK_PERIOD = 10;
  localparam int ND = 10, NF = 6, NO = 8, TPO = 8, TB = 32;
  localparam int NFUSE = NO * TPO * TB;

  logic clk = 0, rst = 1, prog_mode = 0, cfg_shift = 0, cfg_bit = 0;
  logic [ND-1:0] ded_in = '0;
  logic [NF-1:0] fb_in = '0;
  logic [NO-1:0] pin_out, pin_oe;

  int n_vec = 0, n_bad = 0, cyc = 0;
  logic [NFUSE-1:0] img;

  fixed_or_pal i_fixed_or_pal (
    .clk(clk), .rst(rst), .prog_mode(prog_mode), .cfg_shift(cfg_shift),
    .cfg_bit(cfg_bit), .ded_in(ded_in), .fb_in(fb_in),
    .pin_out(pin_out), .pin_oe(pin_oe));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog expired");
      report();
    end
  end

  task automatic chk(string tag, logic [15:0] got, logic [15:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // tmask/cmask: connect true/complement line of signal s (fb k is s=10+k)
  task automatic set_term(int o, int t, logic [15:0] tmask, logic [15:0] cmask);
    int b = (o * TPO + t) * TB;
    for (int s = 0; s < 16; s++) begin
      img[b + 2*s]     = tmask[s];
      img[b + 2*s + 1] = cmask[s];
    end
  endtask

  function automatic logic [15:0] ref_eval(logic [NFUSE-1:0] m, logic [9:0] d, logic [5:0] f);
    logic [15:0] s = {f, d};
    logic [7:0] oe = '0, q = '0;
    for (int o = 0; o < NO; o++) begin
      logic acc = 0;
      for (int t = 0; t < TPO; t++) begin
        int b = (o * TPO + t) * TB;
        logic prod = 1;
        for (int k = 0; k < 16; k++) begin
          if (m[b + 2*k] && !s[k])    prod = 0;
          if (m[b + 2*k + 1] && s[k]) prod = 0;
        end
        if (t == 0) oe[o] = prod;
        else acc = acc | prod;
      end
      q[o] = ~acc;
    end
    return {oe, q};
  endfunction

  task automatic apply(logic [9:0] d, logic [5:0] ext);
    ded_in = d;
    fb_in  = ext;
    #1;
    repeat (3) begin
      for (int k = 0; k < NF; k++) fb_in[k] = pin_oe[k] ? pin_out[k] : ext[k];
      #1;
    end
  endtask

  task automatic load_image(bit check_hiz);
    @(negedge clk);
    prog_mode = 1;
    for (int i = NFUSE - 1; i >= 0; i--) begin
      cfg_shift = 1;
      cfg_bit   = img[i];
      @(negedge clk);
      if (check_hiz && i == 1000) chk("R4 hiz during load", {pin_oe, 8'h00}, 16'h0000);
    end
    cfg_shift = 0;
    @(negedge clk);
    if (check_hiz) chk("R4 hiz after load", {pin_oe, 8'h00}, 16'h0000);
    prog_mode = 0;
    #1;
  endtask

  task automatic t_reset();
    apply(10'h2A5, 6'h15);
    chk("R1 reset state", {pin_oe, pin_out}, 16'h00FF);
  endtask

  task automatic t_open_enables();
    img = '1;
    for (int o = 0; o < NO; o++) set_term(o, 0, 16'h0, 16'h0);
    load_image(1);
    apply(10'h3FF, 6'h00);
    chk("R5 R7 open enable, dead OR terms", {pin_oe, pin_out}, 16'hFFFF);
    apply(10'h000, 6'h3F);
    chk("R5 R7 open enable, inputs low", {pin_oe, pin_out}, 16'hFFFF);
  endtask

  task automatic t_sop_sweep();
    img = '1;
    set_term(0, 1, 16'h0003, 16'h0000);
    set_term(1, 1, 16'h0003, 16'h0000);
    set_term(1, 2, 16'h2000, 16'h0004);
    set_term(1, 3, 16'h0600, 16'h0100);
    set_term(2, 1, 16'h8000, 16'h4000);
    set_term(2, 7, 16'h0020, 16'h0000);
    set_term(6, 0, 16'h0000, 16'h0000);
    set_term(6, 1, 16'h0038, 16'h0000);
    set_term(6, 4, 16'h0000, 16'h00C0);
    set_term(7, 0, 16'h0200, 16'h0000);
    set_term(7, 1, 16'h0804, 16'h0000);
    load_image(0);
    for (int v = 0; v < 1024; v++) begin
      logic [9:0] d = 10'(v);
      logic [5:0] f = d[5:0] ^ d[9:4];
      apply(d, f);
      chk("R2 R6 R7 R8 sum-of-products sweep", {pin_oe, pin_out}, ref_eval(img, d, f));
    end
  endtask

  task automatic t_ignored_shift();
    logic [9:0] d;
    @(negedge clk);
    prog_mode = 0;
    for (int i = 0; i < 40; i++) begin
      cfg_shift = 1; cfg_bit = i[0] ^ i[2];
      @(negedge clk);
    end
    cfg_shift = 0;
    prog_mode = 1;
    repeat (5) @(negedge clk);
    prog_mode = 0;
    #1;
    for (int v = 0; v < 64; v++) begin
      d = 10'(v * 16 + 3);
      apply(d, ~d[5:0]);
      chk("R3 shift ignored", {pin_oe, pin_out}, ref_eval(img, d, ~d[5:0]));
    end
  endtask

  task automatic t_two_pass();
    img = '1;
    set_term(2, 0, 16'h0000, 16'h0000);
    set_term(2, 1, 16'h0003, 16'h0000);
    set_term(2, 2, 16'h000C, 16'h0000);
    set_term(6, 0, 16'h0000, 16'h0000);
    set_term(6, 1, 16'h1010, 16'h0000);
    set_term(6, 2, 16'h0000, 16'h1010);
    load_image(0);
    for (int v = 0; v < 32; v++) begin
      logic [9:0] d = 10'(v);
      logic h = ~((d[0] & d[1]) | (d[2] & d[3]));
      apply(d, 6'h00);
      chk("R9 helper output", {7'h0, pin_out[2]}, {7'h0, h});
      chk("R9 two-pass output", {7'h0, pin_out[6]}, {7'h0, h ^ d[4]});
    end
  endtask

  task automatic t_reset_again();
    @(negedge clk);
    rst = 1;
    @(negedge clk);
    rst = 0;
    apply(10'h155, 6'h2A);
    chk("R1 reset after load", {pin_oe, pin_out}, 16'h00FF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_open_enables();
    t_sop_sweep();
    t_ignored_shift();
    t_two_pass();
    t_reset_again();
    report();
  end
endmodule